// File: doc/BRIEF.md
# Parallel Configuration Byte Streamer

This block sends a stored configuration image to a programmable target device, one byte at a time, over an eight-bit bus. It also generates the clock that goes with that bus. After reset it keeps the shared enable/status line pulled low for a power-on hold-off. Once it releases the line, it waits until the line actually reads high. Only then does it start clocking bytes out of a byte-wide memory read port, from address zero up to the programmed image length. Each new byte is launched on the falling edge of the generated clock, so the target can capture it on the rising edge.

After the last byte the block keeps the clock running and watches the target's done input. If done does not arrive within a set number of clock rises, the block raises an error flag and pulls the shared line low for a short pulse. This forces the whole image to be sent again. If the target starts a reconfiguration by pulling both the done line and the shared line low, the block stops at once, resets its address and waits for the line to rise again. A separate open-drain output can be pulsed low on request, which asks the target to begin a new configuration.

The open-drain pins are split into a pull-low output and a sensed line input. The wired-AND and the pull-ups are resolved outside the block.

Top module: `cfg_streamer`

## Requirements
- R1: `data_out` only changes on a system clock edge where `dclk` goes from 1 to 0, or while `dclk` is low. It is stable for every cycle in which `dclk` is 1.
- R2: From reset release, `oe_pull` is 1 for exactly HOLD_SHORT clock cycles when `hold_sel` is 0, and for HOLD_LONG cycles when it is 1. After that it drops to 0.
- R3: While `oe_line` is low after the hold-off, no `dclk` edge occurs and `mem_addr` stays at 0. Streaming begins once the line reads high.
- R4: The `dclk` period is 2*HALF system clock cycles while streaming. `dclk` is 0 in reset and whenever the block is not streaming.
- R5: The bytes seen at `dclk` rising edges are memory bytes 0 through `img_len`-1 in address order, each exactly once (`img_len` is at least 1).
- R6: If `cs_n` is low when the last byte has been sent, `dclk` stops at 0 and `err` is 0.
- R7: If `cs_n` stays high for DONE_WAIT `dclk` rises after the last byte, `err` becomes 1 and `oe_pull` is 1 for RETRY_LEN cycles. The image is then sent again from byte 0, and a successful done clears `err`.
- R8: When `cs_n` and `oe_line` are both low while the block is not pulling the line, `dclk` is 0 and `mem_addr` is 0 on the next cycle. A full stream from byte 0 follows once the line is high again.
- R9: A `reinit` request makes `init_low` go to 1 for exactly INIT_LEN cycles. A request made while the pulse is active is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hold_sel | input | 1 | Hold-off select: 0 gives the short count, 1 gives the long count |
| img_len | input | AW | Number of image bytes to send |
| mem_addr | output | AW | Read address into the image memory |
| mem_data | input | 8 | Byte read from the image memory at `mem_addr` |
| data_out | output | 8 | Parallel configuration data |
| dclk | output | 1 | Generated configuration clock |
| oe_pull | output | 1 | 1 pulls the shared enable/status line low |
| oe_line | input | 1 | Sensed level of the shared enable/status line |
| cs_n | input | 1 | Target done / reconfiguration indication, active low |
| reinit | input | 1 | Request a pulse on `init_low` |
| init_low | output | 1 | 1 pulls the target's configuration-start line low |
| err | output | 1 | Done was not seen after the last byte |

## Verification
The assertions check on every cycle that the data bus stays stable while the clock is high, and that the hold-off window has exactly the selected length. They also check that the clock never runs while the block itself holds the line low, that an abort stops the clock and clears the address on the next cycle, and that an error always comes with a pull on the line. Only the bench's scenarios can show the remaining behaviour. This covers correct byte order against the image, the clock period, the exact number of extra clock rises before an error, and the retry from byte 0. It also covers resuming from byte 0 after a mid-stream abort, and the start-pulse length when a second request arrives during a pulse.

// File: rtl/cfg_streamer.sv
module cfg_streamer #(
  parameter int AW         = 16,
  parameter int HOLD_SHORT = 250000,
  parameter int HOLD_LONG  = 12500000,
  parameter int HALF       = 2,
  parameter int DONE_WAIT  = 16,
  parameter int RETRY_LEN  = 8,
  parameter int INIT_LEN   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_sel,
  input  logic [AW-1:0] img_len,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_data,
  output logic [7:0]    data_out,
  output logic          dclk,
  output logic          oe_pull,
  input  logic          oe_line,
  input  logic          cs_n,
  input  logic          reinit,
  output logic          init_low,
  output logic          err
);
  localparam int HMAX = (HOLD_LONG > HOLD_SHORT) ? HOLD_LONG : HOLD_SHORT;
  localparam int HCW  = $clog2(((HMAX > RETRY_LEN) ? HMAX : RETRY_LEN) + 1);
  localparam int DCW  = $clog2(HALF + 1);
  localparam int CCW  = $clog2(DONE_WAIT + 1);
  localparam int ICW  = $clog2(INIT_LEN + 1);

  typedef enum logic [2:0] {S_HOLD, S_WAIT, S_RUN, S_CHK, S_FIN, S_ERR} st_e;

  st_e           st;
  logic [HCW-1:0] hcnt;
  logic [DCW-1:0] dcnt;
  logic [CCW-1:0] ccnt;
  logic [ICW-1:0] icnt;
  logic [AW-1:0]  addr;

  wire            abort    = !cs_n && !oe_line;
  wire            tick     = (dcnt == DCW'(HALF - 1));
  wire [HCW-1:0]  hold_lim = hold_sel ? HCW'(HOLD_LONG - 1) : HCW'(HOLD_SHORT - 1);

  assign mem_addr = addr;
  assign oe_pull  = (st == S_HOLD) || (st == S_ERR);
  assign init_low = (icnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_HOLD;
      hcnt     <= '0;
      dcnt     <= '0;
      ccnt     <= '0;
      addr     <= '0;
      data_out <= '0;
      dclk     <= 1'b0;
      err      <= 1'b0;
    end else begin
      case (st)
        S_HOLD: begin
          if (hcnt == hold_lim) begin
            st   <= S_WAIT;
            hcnt <= '0;
          end else hcnt <= hcnt + 1'b1;
        end
        S_WAIT: begin
          if (oe_line) begin
            st       <= S_RUN;
            data_out <= mem_data;
            addr     <= addr + 1'b1;
            dcnt     <= '0;
          end
        end
        S_RUN, S_CHK: begin
          if (abort) begin
            st   <= S_WAIT;
            addr <= '0;
            dclk <= 1'b0;
          end else if (st == S_CHK && !cs_n) begin
            st   <= S_FIN;
            err  <= 1'b0;
            dclk <= 1'b0;
          end else if (st == S_CHK && ccnt == CCW'(DONE_WAIT)) begin
            st   <= S_ERR;
            err  <= 1'b1;
            dclk <= 1'b0;
            hcnt <= '0;
            addr <= '0;
          end else begin
            dcnt <= tick ? '0 : dcnt + 1'b1;
            if (tick) begin
              dclk <= ~dclk;
              if (dclk && st == S_RUN) begin
                if (addr == img_len) begin
                  st   <= S_CHK;
                  ccnt <= '0;
                end else begin
                  data_out <= mem_data;
                  addr     <= addr + 1'b1;
                end
              end
              if (!dclk && st == S_CHK) ccnt <= ccnt + 1'b1;
            end
          end
        end
        S_FIN: begin
          if (abort) begin
            st   <= S_WAIT;
            addr <= '0;
          end
        end
        S_ERR: begin
          if (hcnt == HCW'(RETRY_LEN - 1)) begin
            st   <= S_WAIT;
            hcnt <= '0;
          end else hcnt <= hcnt + 1'b1;
        end
        default: st <= S_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) icnt <= '0;
    else if (icnt != '0) icnt <= icnt - 1'b1;
    else if (reinit) icnt <= ICW'(INIT_LEN);
  end
endmodule

// File: rtl/cfg_streamer_chk.sv
module cfg_streamer_chk #(
  parameter int AW         = 16,
  parameter int HOLD_SHORT = 250000,
  parameter int HOLD_LONG  = 12500000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hold_sel,
  input logic [AW-1:0] mem_addr,
  input logic [7:0]    data_out,
  input logic          dclk,
  input logic          oe_pull,
  input logic          oe_line,
  input logic          cs_n,
  input logic          init_low,
  input logic          err
);
  logic [31:0] since;
  wire  [31:0] lim = hold_sel ? 32'(HOLD_LONG) : 32'(HOLD_SHORT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since <= '0;
    else if (since <= lim) since <= since + 1;
  end

  AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    dclk |-> $stable(data_out)); // R1
  AST_HOLD_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (since < lim) |-> oe_pull); // R2
  AST_HOLD_END: assert property (@(posedge clk) disable iff (!rst_n)
    (since == lim) |-> !oe_pull); // R2
  AST_NO_CLK_WHILE_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    oe_pull |-> !dclk); // R3
  AST_ABORT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !oe_line && !oe_pull) |=> (!dclk && mem_addr == '0)); // R8
  AST_ERR_PULLS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> oe_pull); // R7
  AST_INIT_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_low) |=> init_low); // R9
endmodule

bind cfg_streamer cfg_streamer_chk #(.AW(AW), .HOLD_SHORT(HOLD_SHORT), .HOLD_LONG(HOLD_LONG)) u_chk (.*);

// File: tb/tb_cfg_streamer.sv
module tb_cfg_streamer;
  localparam int AW = 8, HS = 20, HL = 45, HALF = 2, DW = 6, RL = 5, IL = 4;
  localparam int PER = 2 * HALF * 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, hold_sel, cs_n, reinit, tgt_oe_low;
  logic [AW-1:0] img_len, mem_addr;
  logic [7:0]    mem_data, data_out;
  logic          dclk, oe_pull, oe_line, init_low, err;
  logic [7:0]    img [0:255];

  assign oe_line  = !(oe_pull || tgt_oe_low);
  assign mem_data = img[mem_addr];

  cfg_streamer #(.AW(AW), .HOLD_SHORT(HS), .HOLD_LONG(HL), .HALF(HALF),
                 .DONE_WAIT(DW), .RETRY_LEN(RL), .INIT_LEN(IL)) dut (
    .clk(clk), .rst_n(rst_n), .hold_sel(hold_sel), .img_len(img_len),
    .mem_addr(mem_addr), .mem_data(mem_data), .data_out(data_out), .dclk(dclk),
    .oe_pull(oe_pull), .oe_line(oe_line), .cs_n(cs_n), .reinit(reinit),
    .init_low(init_low), .err(err));

  int checks = 0, fails = 0, cyc = 0, n;
  bit finished = 0;
  bit tgt_on = 0, tgt_ack = 0, rise_ok = 0;
  int tgt_idx = 0, tgt_len = 0, extra_rises = 0;
  time last_rise;
  logic [7:0] held;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !finished) begin
      chk(0, "R5 watchdog", cyc, 150000);
      summary();
      $finish;
    end
  end

  // target model: samples on dclk rise
  always @(posedge dclk) begin
    held = data_out;
    if (tgt_on) begin
      if (rise_ok) chk(($time - last_rise) == PER, "R4 dclk period", int'($time - last_rise), PER);
      last_rise = $time;
      rise_ok = 1;
      if (tgt_idx < tgt_len) begin
        chk(data_out == img[tgt_idx], "R5 byte", data_out, img[tgt_idx]);
        tgt_idx++;
        if (tgt_idx == tgt_len && tgt_ack) cs_n = 1'b0;
      end else extra_rises++;
    end
  end

  always @(negedge clk)
    if (tgt_on && dclk) chk(data_out == held, "R1 data stable while dclk high", data_out, held);

  task automatic start_tgt(int len, bit ack);
    for (int i = 0; i < len; i++) img[i] = 8'($urandom);
    img_len = AW'(len);
    tgt_idx = 0; tgt_len = len; tgt_ack = ack;
    extra_rises = 0; rise_ok = 0; tgt_on = 1;
  endtask

  task automatic do_reset(bit sel, int lim);
    rst_n = 0; hold_sel = sel;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(oe_pull && !dclk && !err && !init_low, "R4 reset state", {oe_pull, dclk, err, init_low}, 4'b1000);
    n = 0;
    while (oe_pull) begin n++; @(negedge clk); end
    chk(n == lim, "R2 hold-off length", n, lim);
  endtask

  task automatic finish_ok(int len);
    while (tgt_idx < len) @(negedge clk);
    repeat (4 * HALF) @(negedge clk);
    chk(extra_rises == 0, "R5 no extra rises", extra_rises, 0);
    n = 0;
    repeat (10) begin @(negedge clk); if (dclk) n++; end
    chk(n == 0, "R6 dclk idle after done", n, 0);
    chk(err == 0, "R6 err clear", err, 0);
  endtask

  task automatic reconf(int len, bit ack);
    tgt_on = 0;
    @(negedge clk);
    cs_n = 0; tgt_oe_low = 1;
    repeat (3) @(negedge clk);
    chk(!dclk && mem_addr == 0, "R8 idle after reconfig", int'(mem_addr), 0);
    start_tgt(len, ack);
    cs_n = 1;
    @(negedge clk);
    tgt_oe_low = 0;
  endtask

  initial begin
    void'($urandom(32'd7));
    cs_n = 1; reinit = 0; tgt_oe_low = 1; img_len = 1;
    for (int i = 0; i < 256; i++) img[i] = 8'h00;

    // short hold-off with target extending it (R2, R3)
    do_reset(0, HS);
    n = 0;
    repeat (12) begin @(negedge clk); if (dclk || mem_addr != 0) n++; end
    chk(n == 0, "R3 no clock while line low", n, 0);
    start_tgt(5, 1);
    tgt_oe_low = 0;
    finish_ok(5);

    // random images (R5)
    for (int r = 0; r < 6; r++) begin
      int len = $urandom_range(2, 60);
      reconf(len, 1);
      finish_ok(len);
    end

    // single byte image (R5)
    reconf(1, 1);
    finish_ok(1);

    // missing done: error and retry (R7)
    reconf(8, 0);
    while (!err) @(negedge clk);
    chk(extra_rises == DW, "R7 rises before error", extra_rises, DW);
    chk(oe_pull == 1, "R7 line pulled on error", oe_pull, 1);
    tgt_idx = 0; tgt_ack = 1; rise_ok = 0; extra_rises = 0;
    n = 0;
    while (oe_pull) begin n++; @(negedge clk); end
    chk(n == RL, "R7 retry pulse length", n, RL);
    finish_ok(8);

    // abort mid stream (R8)
    reconf(30, 1);
    while (tgt_idx < 12) @(negedge clk);
    cs_n = 0; tgt_oe_low = 1; tgt_on = 0;
    @(negedge clk);
    chk(!dclk && mem_addr == 0, "R8 abort stops clock", {dclk, mem_addr}, 0);
    n = 0;
    repeat (6) begin @(negedge clk); if (dclk) n++; end
    chk(n == 0, "R8 idle during abort", n, 0);
    start_tgt(30, 1);
    cs_n = 1;
    @(negedge clk);
    tgt_oe_low = 0;
    finish_ok(30);

    // long hold-off (R2)
    tgt_on = 0; tgt_oe_low = 0; cs_n = 1;
    start_tgt(10, 1);
    do_reset(1, HL);
    finish_ok(10);

    // start pulse, with a repeat request ignored (R9)
    @(negedge clk); reinit = 1;
    @(negedge clk); reinit = 0;
    n = 0;
    while (init_low) begin n++; @(negedge clk); end
    chk(n == IL, "R9 init pulse length", n, IL);
    reinit = 1;
    @(negedge clk);
    n = 0;
    while (init_low) begin n++; reinit = (n == 2); @(negedge clk); end
    reinit = 0;
    chk(n == IL, "R9 request during pulse ignored", n, IL);
    n = 0;
    repeat (6) begin @(negedge clk); if (init_low) n++; end
    chk(n == 0, "R9 no retrigger", n, 0);

    finished = 1;
    summary();
    $finish;
  end
endmodule